// File: doc/BRIEF.md
# Prime-Power Exponent Extractor

This block recovers one element of a sequence that has been packed into a single unsigned integer as a product of prime powers. The caller supplies the packed integer and an element index. The block looks up the prime that belongs to that index and divides the integer by it again and again. It stops at the first division that leaves a nonzero remainder. The number of exact divisions before that point is the exponent, and the exponent is the value of the element.

A one-cycle `start` pulse hands over a request. The block accepts it only while it is idle. When the work is finished, `done` pulses for one cycle. In that cycle `exp_out` holds the exponent and `err` marks a request that could not be served. An index beyond the internal prime table is rejected, and so is a packed value of zero. A packed value of zero would otherwise divide forever.

The controller is a five-state machine:
- ST_IDLE waits for a start.
- ST_SELECT checks the request and either launches the first trial division or rejects the request.
- ST_DIVIDE waits for the serial divider.
- ST_JUDGE reads the remainder. On an exact division it launches the next division on the quotient; otherwise it stops.
- ST_REPORT raises `done` for one cycle.

The transitions are:
- idle→select on start.
- select→divide on a valid request.
- select→report on a rejected request.
- divide→judge when the divider finishes.
- judge→divide on a zero remainder.
- judge→report on a nonzero remainder.
- report→idle always.

Top module: `prime_exp_extract`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `err` and `exp_out` are all zero.
- R2: Index k selects the k-th prime counting from zero (2, 3, 5, 7, 11, … up to 53 for k=15). For example, value 12 yields exponents 2, 1 and 0 for indices 0, 1 and 2.
- R3: For a nonzero value and an index in range, `exp_out` equals the number of times the selected prime divides the value exactly. Examples: 8 at index 0 gives 3, 6 gives 1 at both index 0 and index 1, 32768 at index 0 gives 15, and 2809 at index 15 gives 2.
- R4: A value of 1 yields exponent 0 with `err` low for every index from 0 to 15.
- R5: A value of 0 finishes with `err` high and `exp_out` zero.
- R6: An index of 16 or more (past the 16-entry prime table) finishes with `err` high and `exp_out` zero.
- R7: Each accepted start produces exactly one `done` pulse, and that pulse lasts one cycle. `done` never rises without a pending request.
- R8: A start raised while a request is in progress is ignored, and the result still belongs to the accepted request. `exp_out` and `err` change only in the cycle where `done` rises, and they hold afterwards until the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; taken only when idle |
| num_in | input | N_W (16) | Packed prime-power value |
| idx_in | input | IDX_W (5) | Index of the prime whose exponent is wanted |
| exp_out | output | EXP_W (5) | Exponent result, valid with `done` and held afterwards |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request rejected (zero value or index out of range) |

## Verification
The hardest case to reach is a second start that arrives while a division chain is still running. From the outside, a controller that dropped it looks the same as one that restarted on the new operands, unless the two requests give different answers. The stimulus therefore begins with value 12 at index 0 and then holds start high with value 8 for several cycles during the first trial division. A correct block returns 2, while a restarted one returns 3. The bench then watches for a stray second `done` and checks that the held result does not move. The longest division chain is reached with 32768 (fifteen exact divisions), and the last table entry is reached with 2809 = 53².

// File: rtl/pexp_pkg.sv
package pexp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_DIVIDE,
        ST_JUDGE,
        ST_REPORT
    } pexp_state_e;

    // k-th prime counting from zero (k=0 -> 2), by trial division
    function automatic int unsigned nth_prime(input int unsigned k);
        int unsigned found;
        int unsigned cand;
        bit          is_p;
        found = 0;
        cand  = 1;
        while (found <= k) begin
            cand = cand + 1;
            is_p = 1'b1;
            for (int unsigned d = 2; d * d <= cand; d++) begin
                if (cand % d == 0) is_p = 1'b0;
            end
            if (is_p) found = found + 1;
        end
        return cand;
    endfunction

endpackage

// File: rtl/pexp_prime_table.sv
module pexp_prime_table #(
    parameter int NUM_PRIMES = 16,
    parameter int IDX_W      = 5,
    parameter int PW         = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [PW-1:0]    prime,
    output logic             in_range
);

    logic [PW-1:0] tbl [NUM_PRIMES];

    for (genvar g = 0; g < NUM_PRIMES; g++) begin : g_entry
        localparam int unsigned PVAL = pexp_pkg::nth_prime(g);
        assign tbl[g] = PVAL[PW-1:0];
    end

    always_comb begin
        prime    = PW'(2);
        in_range = 1'b0;
        for (int k = 0; k < NUM_PRIMES; k++) begin
            if (32'(idx) == k) begin
                prime    = tbl[k];
                in_range = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pexp_serial_div.sv
module pexp_serial_div #(
    parameter int N_W = 16,
    parameter int PW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [N_W-1:0] dividend,
    input  logic [PW-1:0]  divisor,
    output logic           fin,
    output logic [N_W-1:0] quot,
    output logic [PW-1:0]  rem
);

    localparam int CW = $clog2(N_W + 1);

    logic [CW-1:0]  steps_q;
    logic           run_q;
    logic           fin_q;
    logic [N_W-1:0] quot_q;
    logic [PW-1:0]  rem_q;
    logic [PW-1:0]  dsr_q;
    logic [PW:0]    shifted;
    logic [PW:0]    diff;
    logic           fits;

    assign shifted = {rem_q, quot_q[N_W-1]};
    assign diff    = shifted - {1'b0, dsr_q};
    assign fits    = shifted >= {1'b0, dsr_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_q <= '0;
            run_q   <= 1'b0;
            fin_q   <= 1'b0;
            quot_q  <= '0;
            rem_q   <= '0;
            dsr_q   <= '0;
        end else begin
            fin_q <= 1'b0;
            if (go) begin
                quot_q  <= dividend;
                rem_q   <= '0;
                dsr_q   <= divisor;
                steps_q <= CW'(N_W);
                run_q   <= 1'b1;
            end else if (run_q) begin
                if (fits) begin
                    rem_q  <= diff[PW-1:0];
                    quot_q <= {quot_q[N_W-2:0], 1'b1};
                end else begin
                    rem_q  <= shifted[PW-1:0];
                    quot_q <= {quot_q[N_W-2:0], 1'b0};
                end
                steps_q <= steps_q - CW'(1);
                if (steps_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin  = fin_q;
    assign quot = quot_q;
    assign rem  = rem_q;

endmodule

// File: rtl/prime_exp_extract.sv
module prime_exp_extract #(
    parameter int N_W        = 16,
    parameter int IDX_W      = 5,
    parameter int NUM_PRIMES = 16,
    parameter int PW         = 8,
    parameter int EXP_W      = $clog2(N_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N_W-1:0]   num_in,
    input  logic [IDX_W-1:0] idx_in,
    output logic [EXP_W-1:0] exp_out,
    output logic             done,
    output logic             err
);

    import pexp_pkg::*;

    pexp_state_e state_q, state_d;

    logic [N_W-1:0]   work_q;
    logic [IDX_W-1:0] idx_q;
    logic [EXP_W-1:0] count_q;
    logic [EXP_W-1:0] res_q;
    logic             err_q;

    logic [PW-1:0]    prime_w;
    logic             idx_ok;
    logic             req_ok;
    logic             rem_zero;
    logic             div_go;
    logic             div_fin;
    logic [N_W-1:0]   div_dividend;
    logic [N_W-1:0]   div_quot;
    logic [PW-1:0]    div_rem;
    logic             idle_w;
    logic             enter_report;

    pexp_prime_table #(
        .NUM_PRIMES (NUM_PRIMES),
        .IDX_W      (IDX_W),
        .PW         (PW)
    ) table_i (
        .idx      (idx_q),
        .prime    (prime_w),
        .in_range (idx_ok)
    );

    pexp_serial_div #(
        .N_W (N_W),
        .PW  (PW)
    ) div_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_dividend),
        .divisor  (prime_w),
        .fin      (div_fin),
        .quot     (div_quot),
        .rem      (div_rem)
    );

    assign req_ok   = idx_ok && (work_q != '0);
    assign rem_zero = (div_rem == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_SELECT;
            ST_SELECT: state_d = req_ok ? ST_DIVIDE : ST_REPORT;
            ST_DIVIDE: if (div_fin) state_d = ST_JUDGE;
            ST_JUDGE:  state_d = rem_zero ? ST_DIVIDE : ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        div_go       = 1'b0;
        div_dividend = work_q;
        done         = 1'b0;
        idle_w       = 1'b0;
        unique case (state_q)
            ST_IDLE:   idle_w = 1'b1;
            ST_SELECT: div_go = req_ok;
            ST_DIVIDE: ;
            ST_JUDGE: begin
                div_go       = rem_zero;
                div_dividend = div_quot;
            end
            ST_REPORT: done = 1'b1;
            default:   ;
        endcase
    end

    assign enter_report = (state_d == ST_REPORT) && (state_q != ST_REPORT);

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work_q  <= '0;
            idx_q   <= '0;
            count_q <= '0;
            res_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            if (idle_w && start) begin
                work_q  <= num_in;
                idx_q   <= idx_in;
                count_q <= '0;
            end
            if (state_q == ST_JUDGE && rem_zero) begin
                work_q  <= div_quot;
                count_q <= count_q + EXP_W'(1);
            end
            if (enter_report) begin
                res_q <= (state_q == ST_SELECT) ? '0 : count_q;
                err_q <= (state_q == ST_SELECT);
            end
        end
    end

    assign exp_out = res_q;
    assign err     = err_q;

endmodule

// File: rtl/prime_exp_extract_chk.sv
module prime_exp_extract_chk #(
    parameter int N_W        = 16,
    parameter int IDX_W      = 5,
    parameter int NUM_PRIMES = 16,
    parameter int EXP_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [N_W-1:0]   num_in,
    input logic [IDX_W-1:0] idx_in,
    input logic [EXP_W-1:0] exp_out,
    input logic             done,
    input logic             err,
    input logic             idle
);

    logic [N_W-1:0]   cap_num;
    logic [IDX_W-1:0] cap_idx;
    logic             pending;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_num <= '0;
            cap_idx <= '0;
            pending <= 1'b0;
        end else if (start && idle) begin
            cap_num <= num_in;
            cap_idx <= idx_in;
            pending <= 1'b1;
        end else if (done) begin
            pending <= 1'b0;
        end
    end

    assert_done_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pending);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_zero_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_num == '0) |-> (err && exp_out == '0));

    assert_bad_index_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && 32'(cap_idx) >= NUM_PRIMES) |-> (err && exp_out == '0));

    assert_unit_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_num == N_W'(1) && 32'(cap_idx) < NUM_PRIMES) |-> (!err && exp_out == '0));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(done) |-> ($stable(exp_out) && $stable(err)));

endmodule

bind prime_exp_extract prime_exp_extract_chk #(
    .N_W        (N_W),
    .IDX_W      (IDX_W),
    .NUM_PRIMES (NUM_PRIMES),
    .EXP_W      (EXP_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .num_in  (num_in),
    .idx_in  (idx_in),
    .exp_out (exp_out),
    .done    (done),
    .err     (err),
    .idle    (idle_w)
);

// File: tb/prime_exp_extract_tb_top.sv
module prime_exp_extract_tb_top;

    localparam int N_W   = 16;
    localparam int IDX_W = 5;
    localparam int EXP_W = 5;
    localparam int NV    = 16;

    // vectors: value, index, expected exponent, expected error
    localparam int V_NUM [NV] = '{12, 12, 12, 8, 6, 6, 1, 1, 0, 5, 32768, 2809, 65535, 59049, 8, 6};
    localparam int V_IDX [NV] = '{0, 1, 2, 0, 0, 1, 0, 15, 3, 20, 0, 15, 0, 1, 1, 2};
    localparam int V_EXP [NV] = '{2, 1, 0, 3, 1, 1, 0, 0, 0, 0, 15, 2, 0, 10, 0, 0};
    localparam int V_ERR [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [N_W-1:0]   num_in = '0;
    logic [IDX_W-1:0] idx_in = '0;
    logic [EXP_W-1:0] exp_out;
    logic             done;
    logic             err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    prime_exp_extract dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .num_in  (num_in),
        .idx_in  (idx_in),
        .exp_out (exp_out),
        .done    (done),
        .err     (err)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic issue(input int num, input int idx);
        @(negedge clk);
        num_in = N_W'(num);
        idx_in = IDX_W'(idx);
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    // waits for done; returns 1 if seen, sampled at negedge
    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int t = 0; t < 5000 && !seen; t++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    task automatic run_case(input int num, input int idx, input int e_exp, input int e_err, input string req);
        bit seen;
        issue(num, idx);
        wait_done(seen);
        check(seen, {req, " done"}, int'(seen), 1);
        check(int'(exp_out) == e_exp, {req, " exponent"}, int'(exp_out), e_exp);
        check(int'(err) == e_err, {req, " error"}, int'(err), e_err);
        @(negedge clk);
        check(!done, {req, " done width R7"}, int'(done), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 200000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit seen;
        int dcount;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!done && !err && exp_out == '0, "R1 reset outputs", int'(exp_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !err && exp_out == '0, "R1 after reset", int'(done), 0);

        // table of vectors: R2, R3, R4, R5, R6
        for (int v = 0; v < NV; v++) begin
            run_case(V_NUM[v], V_IDX[v], V_EXP[v], V_ERR[v], $sformatf("R2/R3 vector %0d", v));
        end

        // R4: value 1 at every index in range
        for (int k = 0; k < 16; k++) begin
            run_case(1, k, 0, 0, $sformatf("R4 index %0d", k));
        end

        // R5 and R6 directed
        run_case(0, 0, 0, 1, "R5 zero value");
        run_case(64, 16, 0, 1, "R6 index 16");
        run_case(64, 31, 0, 1, "R6 index 31");

        // R8: start while busy is ignored
        issue(12, 0);
        num_in = N_W'(8);
        start  = 1'b1;
        repeat (3) @(negedge clk);
        start  = 1'b0;
        wait_done(seen);
        check(seen, "R8 busy done", int'(seen), 1);
        check(exp_out == EXP_W'(2), "R8 busy result", int'(exp_out), 2);
        // R7: no second done pulse
        dcount = 0;
        for (int t = 0; t < 60; t++) begin
            @(negedge clk);
            if (done) dcount++;
        end
        check(dcount == 0, "R7 single done", dcount, 0);
        // R8: result held after done
        check(exp_out == EXP_W'(2) && !err, "R8 hold", int'(exp_out), 2);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule